// File: doc/BRIEF.md
# Soft Mute Gain Ramp Sequencer

This block gives a stereo DAC path a click-free digital mute. It sits between the register file and the per-channel digital attenuators. When software changes the mute field of the DAC control register, the block does not jump the attenuation. It moves the applied attenuation of each channel one step per sample strobe toward the new target. Mute ramps toward full attenuation (31, which is -31 dB) and then gates the output to silence. Unmute clears the silence gate and ramps back to the programmed per-channel gain.

When a ramp completes, the block sends a one-cycle event to the interrupt flag unit. A finished mute ramp raises the gain-down event, and a finished unmute ramp raises the gain-up event. If the mute field flips again in the middle of a ramp, the ramp turns around from its current value, and only the direction that finally completes raises its event.

While the DAC is in standby, no ramp runs. The attenuation and the gate follow the target at once, and no event is raised. Outside a ramp, the applied attenuation tracks the programmed gains directly. A gang control lets the left gain drive both channels.

Top module: `softmute_ramp`

## Requirements
- R1: After reset, both applied attenuations are 31, the silence gate is 1 and neither event is asserted.
- R2: A write that sets the mute field (control bit 7) while the standby field (control bit 4) is 0 starts a down ramp. Each strobe raises each channel's attenuation by 1 until it reaches 31. The first strobe that finds both channels at 31 ends the ramp: after that edge the silence gate is 1 and the gain-down event is high for exactly one cycle.
- R3: A write that clears the mute field while standby is 0 clears the silence gate at that edge. Each strobe then lowers each channel's attenuation by 1 until it reaches its programmed gain. The first strobe that finds both channels at target raises the gain-up event for exactly one cycle.
- R4: During a ramp, a cycle without a sample strobe leaves both attenuations unchanged.
- R5: A control write whose mute field equals the current mute state starts no ramp and raises no event.
- R6: While standby is 1, a change of the mute field sets the attenuations and the gate to their final values at the write edge, with no event. Setting standby during a ramp aborts the ramp with no event.
- R7: When the gang input is 1, the right channel's unmuted target is the left gain. When it is 0, each channel uses its own gain.
- R8: A mute flip during a ramp reverses the ramp from the current attenuation. Only the direction that completes raises its event.
- R9: When a control write and a sample strobe fall in the same cycle, the strobe steps in the direction set by that write.
- R10: Outside a ramp and out of standby while unmuted, a change of a programmed gain appears on the applied attenuation one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe of the DAC control register |
| ctrl_mute | input | 1 | Mute field of the written value (control bit 7) |
| ctrl_stby | input | 1 | Standby field of the written value (control bit 4) |
| gain_l | input | 5 | Programmed left attenuation, 0 to 31 dB |
| gain_r | input | 5 | Programmed right attenuation, 0 to 31 dB |
| gain_gang | input | 1 | 1: left gain drives both channels |
| sample_stb | input | 1 | One-cycle strobe per audio sample |
| attn_l | output | 5 | Applied left attenuation |
| attn_r | output | 5 | Applied right attenuation |
| out_silence | output | 1 | 1: DAC output gated to silence |
| evt_gain_down | output | 1 | One-cycle pulse when a mute ramp completes |
| evt_gain_up | output | 1 | One-cycle pulse when an unmute ramp completes |

## Verification
A control write and a sample strobe can land in the same cycle. The write may start a ramp or reverse one, and the strobe moves the attenuation. The bench raises both inputs together, once from idle and once mid-ramp with reversal. It checks that the attenuation after that edge has moved one step in the newly written direction. It also checks that the reversed ramp later completes with the matching event and that no event is raised for the abandoned direction.

// File: rtl/softmute_pkg.sv
package softmute_pkg;

  localparam int NUM_CH = 2;

  typedef struct packed {
    logic mute;
    logic stby;
  } dac_ctl_t;

endpackage

// File: rtl/sm_ctl_reg.sv
module sm_ctl_reg
  import softmute_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  dac_ctl_t wr_val,
  output dac_ctl_t ctl_q,
  output dac_ctl_t ctl_nxt,
  output logic     mute_flip
);

  always_comb begin
    ctl_nxt   = wr_en ? wr_val : ctl_q;
    mute_flip = wr_en && (wr_val.mute != ctl_q.mute);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q.mute <= 1'b1;
      ctl_q.stby <= 1'b1;
    end else if (wr_en) begin
      ctl_q <= wr_val;
    end
  end

  // R5
  same_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_val.mute == ctl_q.mute)) |=> (ctl_q.mute == $past(ctl_q.mute)));

endmodule

// File: rtl/sm_chan_step.sv
module sm_chan_step #(
  parameter int GAIN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap,
  input  logic              step_en,
  input  logic [GAIN_W-1:0] tgt,
  output logic [GAIN_W-1:0] att,
  output logic              at_tgt
);

  logic [GAIN_W-1:0] att_q, att_d;

  always_comb begin
    at_tgt = (att_q == tgt);
    att_d  = att_q;
    if (snap) begin
      att_d = tgt;
    end else if (step_en && !at_tgt) begin
      if (att_q < tgt) att_d = att_q + 1'b1;
      else             att_d = att_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) att_q <= '1;
    else        att_q <= att_d;
  end

  assign att = att_q;

  // R4
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap && !step_en) |=> (att_q == $past(att_q)));

  // R2 R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap && step_en && !at_tgt) |=>
      ((att_q == $past(att_q) + 1'b1) || (att_q == $past(att_q) - 1'b1)));

endmodule

// File: rtl/sm_seq.sv
module sm_seq
  import softmute_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  dac_ctl_t ctl_nxt,
  input  logic     mute_flip,
  input  logic     stb,
  input  logic     all_at_tgt,
  output logic     snap,
  output logic     step_en,
  output logic     gate,
  output logic     evt_down,
  output logic     evt_up
);

  logic act_q, act_d, act_n, done;
  logic gate_q, gate_d, dn_q, dn_d, up_q, up_d;

  always_comb begin
    act_n   = !ctl_nxt.stby && (act_q || mute_flip);
    done    = act_n && stb && all_at_tgt;
    act_d   = act_n && !done;
    step_en = act_n && stb && !done;
    snap    = !act_d;
    gate_d  = act_d ? 1'b0 : ctl_nxt.mute;
    dn_d    = done && ctl_nxt.mute;
    up_d    = done && !ctl_nxt.mute;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      gate_q <= 1'b1;
      dn_q   <= 1'b0;
      up_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      gate_q <= gate_d;
      dn_q   <= dn_d;
      up_q   <= up_d;
    end
  end

  assign gate     = gate_q;
  assign evt_down = dn_q;
  assign evt_up   = up_q;

  // R2 R3
  no_dual_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_q && up_q));

  // R6
  stby_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_nxt.stby |=> (!dn_q && !up_q));

  // R2
  down_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_q |=> !dn_q);

endmodule

// File: rtl/softmute_ramp.sv
module softmute_ramp
  import softmute_pkg::*;
#(
  parameter int GAIN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ctrl_mute,
  input  logic              ctrl_stby,
  input  logic [GAIN_W-1:0] gain_l,
  input  logic [GAIN_W-1:0] gain_r,
  input  logic              gain_gang,
  input  logic              sample_stb,
  output logic [GAIN_W-1:0] attn_l,
  output logic [GAIN_W-1:0] attn_r,
  output logic              out_silence,
  output logic              evt_gain_down,
  output logic              evt_gain_up
);

  localparam logic [GAIN_W-1:0] FULL_ATT = '1;

  dac_ctl_t ctl_q, ctl_nxt, wr_val;
  logic     mute_flip, snap, step_en;
  logic [GAIN_W-1:0] prog [NUM_CH];
  logic [GAIN_W-1:0] tgt  [NUM_CH];
  logic [GAIN_W-1:0] att  [NUM_CH];
  logic [NUM_CH-1:0] at_tgt;

  assign wr_val.mute = ctrl_mute;
  assign wr_val.stby = ctrl_stby;

  sm_ctl_reg u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl_wr),
    .wr_val    (wr_val),
    .ctl_q     (ctl_q),
    .ctl_nxt   (ctl_nxt),
    .mute_flip (mute_flip)
  );

  // R7: right channel follows the left gain when ganged
  assign prog[0] = gain_l;
  assign prog[1] = gain_gang ? gain_l : gain_r;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign tgt[c] = ctl_nxt.mute ? FULL_ATT : prog[c];
    sm_chan_step #(.GAIN_W(GAIN_W)) u_step (
      .clk     (clk),
      .rst_n   (rst_n),
      .snap    (snap),
      .step_en (step_en),
      .tgt     (tgt[c]),
      .att     (att[c]),
      .at_tgt  (at_tgt[c])
    );
  end

  sm_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_nxt    (ctl_nxt),
    .mute_flip  (mute_flip),
    .stb        (sample_stb),
    .all_at_tgt (&at_tgt),
    .snap       (snap),
    .step_en    (step_en),
    .gate       (out_silence),
    .evt_down   (evt_gain_down),
    .evt_up     (evt_gain_up)
  );

  assign attn_l = att[0];
  assign attn_r = att[1];

  // R2
  silence_full_att_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_silence |-> ((attn_l == FULL_ATT) && (attn_r == FULL_ATT)));

  // R6
  stby_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.stby && !ctrl_wr) |=> (out_silence == ctl_q.mute));

endmodule

// File: tb/softmute_ramp_tb_top.sv
`timescale 1ns/1ps
module softmute_ramp_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0, ctrl_mute = 1'b0, ctrl_stby = 1'b0;
  logic [4:0] gain_l = 5'd0, gain_r = 5'd0;
  logic       gain_gang = 1'b0, sample_stb = 1'b0;
  logic [4:0] attn_l, attn_r;
  logic       out_silence, evt_gain_down, evt_gain_up;

  int n_tests = 0, n_fail = 0;
  int n_dn = 0, n_up = 0;

  always #4 clk = ~clk;

  softmute_ramp dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_mute(ctrl_mute),
    .ctrl_stby(ctrl_stby), .gain_l(gain_l), .gain_r(gain_r),
    .gain_gang(gain_gang), .sample_stb(sample_stb), .attn_l(attn_l),
    .attn_r(attn_r), .out_silence(out_silence),
    .evt_gain_down(evt_gain_down), .evt_gain_up(evt_gain_up)
  );

  always @(negedge clk) begin
    if (evt_gain_down) n_dn++;
    if (evt_gain_up)   n_up++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic m, input logic s);
    ctrl_wr = 1'b1; ctrl_mute = m; ctrl_stby = s;
    tick();
    ctrl_wr = 1'b0;
  endtask

  task automatic strobe();
    sample_stb = 1'b1;
    tick();
    sample_stb = 1'b0;
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // Full ramp from the current idle state; down=1 mutes, down=0 unmutes.
  task automatic ramp(input bit down, input int gl, input int gr);
    int kfin, el, er;
    kfin = imax(31 - gl, 31 - gr) + 1;
    wr(down, 1'b0);
    chk(down ? "R2" : "R3", "gate after write", out_silence, 0);
    for (int k = 1; k <= kfin; k++) begin
      strobe();
      if (k < kfin) begin
        el = down ? imin(31, gl + k) : imax(gl, 31 - k);
        er = down ? imin(31, gr + k) : imax(gr, 31 - k);
        chk(down ? "R2" : "R3", "left step", attn_l, el);
        chk(down ? "R2" : "R3", "right step", attn_r, er);
        chk(down ? "R2" : "R3", "no early event", evt_gain_down | evt_gain_up, 0);
        if (k == 2) begin
          tick();
          chk("R4", "left hold", attn_l, el);
          chk("R4", "right hold", attn_r, er);
        end
      end else begin
        chk(down ? "R2" : "R3", "final left", attn_l, down ? 31 : gl);
        chk(down ? "R2" : "R3", "final right", attn_r, down ? 31 : gr);
        chk(down ? "R2" : "R3", "gate at end", out_silence, down ? 1 : 0);
        chk(down ? "R2" : "R3", "event", down ? evt_gain_down : evt_gain_up, 1);
        chk(down ? "R2" : "R3", "other event", down ? evt_gain_up : evt_gain_down, 0);
      end
    end
    tick();
    chk(down ? "R2" : "R3", "event one cycle", evt_gain_down | evt_gain_up, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int sd, su, gre;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1
    chk("R1", "left reset", attn_l, 31);
    chk("R1", "right reset", attn_r, 31);
    chk("R1", "gate reset", out_silence, 1);
    chk("R1", "events reset", n_dn + n_up, 0);

    // R5: leave standby keeping mute=1, no ramp
    wr(1'b1, 1'b0);
    repeat (3) strobe();
    tick();
    chk("R5", "gate kept", out_silence, 1);
    chk("R5", "no event", n_dn + n_up, 0);

    // Sweep every left gain, with derived right gain and gang
    for (int g = 0; g < 32; g++) begin
      gain_l = 5'(g);
      gain_r = 5'((g * 13 + 5) % 32);
      gain_gang = (g % 4 == 0);
      gre = gain_gang ? g : (g * 13 + 5) % 32;
      ramp(1'b0, g, gre);
      if (gain_gang) chk("R7", "ganged right", attn_r, g);
      ramp(1'b1, g, gre);
    end
    gain_gang = 1'b0;

    // R5 again while muted and idle
    sd = n_dn; su = n_up;
    wr(1'b1, 1'b0);
    repeat (4) strobe();
    chk("R5", "att kept", attn_l, 31);
    chk("R5", "no event", (n_dn - sd) + (n_up - su), 0);

    gain_l = 5'd10; gain_r = 5'd20;
    ramp(1'b0, 10, 20);

    // R10
    gain_l = 5'd4; tick();
    chk("R10", "gain follow", attn_l, 4);
    gain_l = 5'd10; tick();

    // R7
    gain_gang = 1'b1; tick();
    chk("R7", "gang on", attn_r, 10);
    gain_gang = 1'b0; tick();
    chk("R7", "gang off", attn_r, 20);

    // R8 reversal mid-ramp
    sd = n_dn; su = n_up;
    wr(1'b1, 1'b0);
    repeat (5) strobe();
    chk("R8", "mid left", attn_l, 15);
    chk("R8", "mid right", attn_r, 25);
    wr(1'b0, 1'b0);
    chk("R8", "reversed gate", out_silence, 0);
    chk("R8", "no jump", attn_l, 15);
    for (int k = 1; k <= 5; k++) begin
      strobe();
      chk("R8", "back left", attn_l, 15 - k);
      chk("R8", "back right", attn_r, 25 - k);
    end
    strobe();
    chk("R8", "up event", evt_gain_up, 1);
    tick();
    chk("R8", "no down event", n_dn - sd, 0);
    chk("R8", "one up event", n_up - su, 1);

    // R9 write and strobe in the same cycle
    sd = n_dn; su = n_up;
    ctrl_wr = 1'b1; ctrl_mute = 1'b1; ctrl_stby = 1'b0; sample_stb = 1'b1;
    tick();
    chk("R9", "down step left", attn_l, 11);
    chk("R9", "down step right", attn_r, 21);
    ctrl_mute = 1'b0;
    tick();
    ctrl_wr = 1'b0; sample_stb = 1'b0;
    chk("R9", "reverse step left", attn_l, 10);
    chk("R9", "reverse step right", attn_r, 20);
    strobe();
    chk("R9", "up event", evt_gain_up, 1);
    tick();
    chk("R9", "no down event", n_dn - sd, 0);

    // R6 standby
    sd = n_dn; su = n_up;
    wr(1'b1, 1'b1);
    chk("R6", "snap mute", attn_l, 31);
    chk("R6", "snap gate", out_silence, 1);
    wr(1'b0, 1'b1);
    chk("R6", "snap unmute left", attn_l, 10);
    chk("R6", "snap unmute right", attn_r, 20);
    chk("R6", "snap unmute gate", out_silence, 0);
    wr(1'b0, 1'b0);
    wr(1'b1, 1'b0);
    repeat (3) strobe();
    chk("R6", "ramp before abort", attn_l, 13);
    wr(1'b1, 1'b1);
    chk("R6", "abort left", attn_l, 31);
    chk("R6", "abort right", attn_r, 31);
    chk("R6", "abort gate", out_silence, 1);
    repeat (40) strobe();
    tick();
    chk("R6", "no events", (n_dn - sd) + (n_up - su), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule